// File: doc/BRIEF.md
# Row-Shifting Unified Issue Queue

This block holds renamed instructions until their source operands are available and then hands each one to an execution unit. One queue serves every unit type. Slots form a grid of `COLS` columns (the decode width) by `ROWS` rows. An accepted push always inserts one whole row at the youngest end and moves every existing row one step toward the oldest end. The queue never closes up empty rows, so a slot's position alone gives its age. A slot with a higher row number is older. Within a row, a lower column is older.

Each source of an incoming instruction is resolved once, at push time, into one of three cases:
- **Satisfied:** the source is not pending, or its producer is completing or issuing in that same cycle.
- **In-queue producer:** the source is recorded as a bit in a lower-triangular dependency matrix. The bit is cleared when that producer issues.
- **External producer:** the source waits for a completion broadcast that carries the producer's ROB ID.

On every cycle, each unit port receives the oldest ready slot whose unit field selects that port. A flush empties the queue in one cycle.

Top module: `iq_row_queue`

## Requirements
- R1: After reset no issue port is valid and `push_ready` is high.
- R2: An accepted push writes all `COLS` slots as one new youngest row, whether or not each slot is valid, and moves every older row by one. Slot s of the push row lands in column s. Slots with `push_slot_valid` low never issue.
- R3: `push_ready` is low whenever any slot of the oldest row (row `ROWS-1`) is valid. A push offered while it is low is dropped and never issues.
- R4: When several ready slots target the same unit, the oldest one issues. Age runs by push order of rows, and within one row column 0 is older than column 1.
- R5: A slot whose unit field holds value u issues only on port u. Each port issues at most one slot per cycle.
- R6: A pending source is released only by a wake broadcast, on any wake port, whose ROB ID equals the source's ROB ID. A broadcast with any other ROB ID has no effect.
- R7: A source whose ROB ID matches a valid queued slot, or an older valid slot in the same push row, waits for that producer. The consumer becomes eligible in the cycle after the producer issues.
- R8: A pending source counts as satisfied when, in its push cycle, a wake broadcast carries its ROB ID or its queued producer is issuing.
- R9: An issued slot leaves the queue on the edge that ends its issue cycle and is never issued again.
- R10: `flush` empties the queue in one cycle and drops any push offered in that cycle. Afterwards nothing issues, even after wakes, and `push_ready` is high.
- R11: A valid slot with no pending source issues in the cycle after it is pushed, provided no older ready slot targets the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty the queue |
| push_valid | input | 1 | Push row offered |
| push_ready | output | 1 | Oldest row is empty, so a push is accepted |
| push_slot_valid | input | COLS | Per-slot instruction present |
| push_unit | input | COLS*UNITW | Per-slot target unit |
| push_rob | input | COLS*ROBW | Per-slot ROB ID |
| push_src_rob | input | COLS*SRCS*ROBW | Source ROB IDs, slot-major |
| push_src_pend | input | COLS*SRCS | Source still waits on its producer |
| wake_valid | input | WAKES | Completion broadcast present |
| wake_rob | input | WAKES*ROBW | ROB ID of each completion |
| issue_valid | output | UNITS | Port u issues this cycle |
| issue_rob | output | UNITS*ROBW | ROB ID issued on each port |

## Verification
Push-time source resolution can coincide with two other activities in the same cycle, and the bench provokes both.

- **Wake in the push cycle:** a row is pushed whose pending source names the ROB ID on a wake port in that same cycle. The check is that the new slot issues on the very next cycle rather than stalling.
- **Producer issuing in the push cycle:** a consumer is pushed while its in-queue producer is visible on an issue port. The check is that the consumer appears on its own port one cycle later.

Flush is also offered together with a push, and the bench checks that the offered row never issues, even after its source is woken.

// File: rtl/iq_pkg.sv
package iq_pkg;

    // Outcome of resolving one incoming source at push time.
    typedef enum logic [1:0] {
        SRC_SATISFIED = 2'd0,
        SRC_EXTERNAL  = 2'd1,
        SRC_INQUEUE   = 2'd2
    } src_kind_e;

    // Age rank 0 is the oldest slot: top row first, low column first.
    function automatic int rank_to_slot(input int rank, input int cols, input int rows);
        return (rows - 1 - rank / cols) * cols + rank % cols;
    endfunction

endpackage

// File: rtl/iq_src_resolve.sv
module iq_src_resolve #(
    parameter int COLS  = 2,
    parameter int ROWS  = 8,
    parameter int ROBW  = 6,
    parameter int WAKES = 2,
    parameter int SLOT  = 0
) (
    input  logic                            pend,
    input  logic [ROBW-1:0]                 src,
    input  logic [COLS*ROWS-1:0]            q_valid,
    input  logic [COLS*ROWS-1:0]            q_live,
    input  logic [COLS*ROWS-1:0][ROBW-1:0]  q_rob,
    input  logic [COLS-1:0]                 row_valid,
    input  logic [COLS-1:0][ROBW-1:0]       row_rob,
    input  logic [WAKES-1:0]                wk_valid,
    input  logic [WAKES-1:0][ROBW-1:0]      wk_rob,
    output logic [COLS*ROWS-1:0]            dep,
    output logic                            wait_ext
);
    import iq_pkg::*;

    localparam int N = COLS * ROWS;
    localparam logic [N-1:0] ONE = N'(1);

    src_kind_e kind;

    always_comb begin
        dep  = '0;
        kind = SRC_SATISFIED;
        if (pend) begin
            kind = SRC_EXTERNAL;
            // queued producers: their slot moves up one row on this push
            for (int j = 0; j < N; j++) begin
                if (q_valid[j] && q_rob[j] == src) begin
                    kind = SRC_INQUEUE;
                    if (q_live[j]) begin
                        dep = dep | (ONE << (j + COLS));
                    end
                end
            end
            // older slots of the same incoming row
            for (int c = 0; c < COLS; c++) begin
                if (c < SLOT && row_valid[c] && row_rob[c] == src) begin
                    kind = SRC_INQUEUE;
                    dep  = dep | (ONE << c);
                end
            end
            for (int w = 0; w < WAKES; w++) begin
                if (kind == SRC_EXTERNAL && wk_valid[w] && wk_rob[w] == src) begin
                    kind = SRC_SATISFIED;
                end
            end
        end
        wait_ext = (kind == SRC_EXTERNAL);
    end

endmodule

// File: rtl/iq_age_select.sv
module iq_age_select #(
    parameter int COLS  = 2,
    parameter int ROWS  = 8,
    parameter int UNITW = 1,
    parameter int UNIT  = 0
) (
    input  logic [COLS*ROWS-1:0]             ready,
    input  logic [COLS*ROWS-1:0][UNITW-1:0]  unit,
    output logic [COLS*ROWS-1:0]             grant,
    output logic                             found,
    output logic [$clog2(COLS*ROWS)-1:0]     idx
);
    localparam int N    = COLS * ROWS;
    localparam int IDXW = $clog2(N);

    always_comb begin
        grant = '0;
        found = 1'b0;
        idx   = '0;
        for (int p = 0; p < N; p++) begin
            if (!found) begin
                if (ready[iq_pkg::rank_to_slot(p, COLS, ROWS)] &&
                    unit[iq_pkg::rank_to_slot(p, COLS, ROWS)] == UNITW'(UNIT)) begin
                    found = 1'b1;
                    grant[iq_pkg::rank_to_slot(p, COLS, ROWS)] = 1'b1;
                    idx   = IDXW'(iq_pkg::rank_to_slot(p, COLS, ROWS));
                end
            end
        end
    end

endmodule

// File: rtl/iq_row_queue.sv
module iq_row_queue #(
    parameter int COLS  = 2,
    parameter int ROWS  = 8,
    parameter int UNITS = 2,
    parameter int ROBW  = 6,
    parameter int SRCS  = 2,
    parameter int WAKES = 2,
    localparam int UNITW = (UNITS > 1) ? $clog2(UNITS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push_valid,
    output logic                         push_ready,
    input  logic [COLS-1:0]              push_slot_valid,
    input  logic [COLS*UNITW-1:0]        push_unit,
    input  logic [COLS*ROBW-1:0]         push_rob,
    input  logic [COLS*SRCS*ROBW-1:0]    push_src_rob,
    input  logic [COLS*SRCS-1:0]         push_src_pend,
    input  logic [WAKES-1:0]             wake_valid,
    input  logic [WAKES*ROBW-1:0]        wake_rob,
    output logic [UNITS-1:0]             issue_valid,
    output logic [UNITS*ROBW-1:0]        issue_rob
);
    localparam int N    = COLS * ROWS;
    localparam int IDXW = $clog2(N);

    // stored state
    logic [N-1:0]                       q_valid;
    logic [N-1:0][UNITW-1:0]            q_unit;
    logic [N-1:0][ROBW-1:0]             q_rob;
    logic [N-1:0][SRCS-1:0][ROBW-1:0]   q_src;
    logic [N-1:0][SRCS-1:0]             q_wait;
    logic [N-1:0][N-1:0]                q_dep;   // [consumer][producer]

    // unpacked views of the flat ports
    logic [COLS-1:0][UNITW-1:0]         in_unit;
    logic [COLS-1:0][ROBW-1:0]          in_rob;
    logic [COLS-1:0][SRCS-1:0][ROBW-1:0] in_src;
    logic [COLS-1:0][SRCS-1:0]          in_pend;
    logic [WAKES-1:0][ROBW-1:0]         wk_rob;

    assign in_unit = push_unit;
    assign in_rob  = push_rob;
    assign in_src  = push_src_rob;
    assign in_pend = push_src_pend;
    assign wk_rob  = wake_rob;

    // readiness and selection
    logic [N-1:0]              ready_vec;
    logic [UNITS-1:0][N-1:0]   grant;
    logic [UNITS-1:0][IDXW-1:0] sel_idx;
    logic [N-1:0]              iss_mask;
    logic [N-1:0]              live;

    always_comb begin
        for (int e = 0; e < N; e++) begin
            ready_vec[e] = q_valid[e] && !(|q_dep[e]) && !(|q_wait[e]);
        end
    end

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        iq_age_select #(
            .COLS (COLS),
            .ROWS (ROWS),
            .UNITW(UNITW),
            .UNIT (u)
        ) u_sel (
            .ready(ready_vec),
            .unit (q_unit),
            .grant(grant[u]),
            .found(issue_valid[u]),
            .idx  (sel_idx[u])
        );
        assign issue_rob[u*ROBW +: ROBW] = q_rob[sel_idx[u]];
    end

    always_comb begin
        iss_mask = '0;
        for (int u = 0; u < UNITS; u++) begin
            iss_mask = iss_mask | grant[u];
        end
    end

    assign live = q_valid & ~iss_mask;

    // state after this cycle's issue and wakes, before any shift
    logic [N-1:0][SRCS-1:0] wait_mid;
    logic [N-1:0][N-1:0]    dep_mid;

    always_comb begin
        for (int e = 0; e < N; e++) begin
            dep_mid[e] = q_dep[e] & ~iss_mask;
            for (int k = 0; k < SRCS; k++) begin
                wait_mid[e][k] = q_wait[e][k];
                for (int w = 0; w < WAKES; w++) begin
                    if (wake_valid[w] && wk_rob[w] == q_src[e][k]) begin
                        wait_mid[e][k] = 1'b0;
                    end
                end
            end
        end
    end

    // push admission
    logic push_fire;
    assign push_ready = !(|q_valid[N-1:N-COLS]);
    assign push_fire  = push_valid && push_ready && !flush;

    // source resolution of the incoming row
    logic [COLS-1:0][SRCS-1:0][N-1:0] dep_new;
    logic [COLS-1:0][SRCS-1:0]        wait_new;

    for (genvar s = 0; s < COLS; s++) begin : g_slot
        for (genvar k = 0; k < SRCS; k++) begin : g_src
            iq_src_resolve #(
                .COLS (COLS),
                .ROWS (ROWS),
                .ROBW (ROBW),
                .WAKES(WAKES),
                .SLOT (s)
            ) u_res (
                .pend     (in_pend[s][k]),
                .src      (in_src[s][k]),
                .q_valid  (q_valid),
                .q_live   (live),
                .q_rob    (q_rob),
                .row_valid(push_slot_valid),
                .row_rob  (in_rob),
                .wk_valid (wake_valid),
                .wk_rob   (wk_rob),
                .dep      (dep_new[s][k]),
                .wait_ext (wait_new[s][k])
            );
        end
    end

    // next state
    logic [N-1:0]                       n_valid;
    logic [N-1:0][UNITW-1:0]            n_unit;
    logic [N-1:0][ROBW-1:0]             n_rob;
    logic [N-1:0][SRCS-1:0][ROBW-1:0]   n_src;
    logic [N-1:0][SRCS-1:0]             n_wait;
    logic [N-1:0][N-1:0]                n_dep;

    always_comb begin
        n_valid = live;
        n_unit  = q_unit;
        n_rob   = q_rob;
        n_src   = q_src;
        n_wait  = wait_mid;
        n_dep   = dep_mid;
        if (push_fire) begin
            for (int e = N - 1; e >= COLS; e--) begin
                n_valid[e] = live[e-COLS];
                n_unit[e]  = q_unit[e-COLS];
                n_rob[e]   = q_rob[e-COLS];
                n_src[e]   = q_src[e-COLS];
                n_wait[e]  = wait_mid[e-COLS];
                n_dep[e]   = '0;
                for (int j = COLS; j < N; j++) begin
                    n_dep[e][j] = dep_mid[e-COLS][j-COLS];
                end
            end
            for (int s = 0; s < COLS; s++) begin
                n_valid[s] = push_slot_valid[s];
                n_unit[s]  = in_unit[s];
                n_rob[s]   = in_rob[s];
                n_src[s]   = in_src[s];
                n_dep[s]   = '0;
                n_wait[s]  = '0;
                if (push_slot_valid[s]) begin
                    for (int k = 0; k < SRCS; k++) begin
                        n_dep[s]     = n_dep[s] | dep_new[s][k];
                        n_wait[s][k] = wait_new[s][k];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= '0;
            q_unit  <= '0;
            q_rob   <= '0;
            q_src   <= '0;
            q_wait  <= '0;
            q_dep   <= '0;
        end else if (flush) begin
            q_valid <= '0;
            q_wait  <= '0;
            q_dep   <= '0;
        end else begin
            q_valid <= n_valid;
            q_unit  <= n_unit;
            q_rob   <= n_rob;
            q_src   <= n_src;
            q_wait  <= n_wait;
            q_dep   <= n_dep;
        end
    end

endmodule

// File: rtl/iq_row_queue_chk.sv
module iq_row_queue_chk #(
    parameter int UNITS = 2,
    parameter int ROBW  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic                    push_valid,
    input logic                    push_ready,
    input logic [UNITS-1:0]        issue_valid,
    input logic [UNITS*ROBW-1:0]   issue_rob
);

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (issue_valid == '0 && push_ready)); // R10

    AST_READY_FALLS_ONLY_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_valid && push_ready && !flush) |=> !$fell(push_ready)); // R3

    for (genvar u = 0; u < UNITS; u++) begin : g_port
        AST_NO_REPEAT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid[u] && !flush) |=>
            !(issue_valid[u] && issue_rob[u*ROBW +: ROBW] == $past(issue_rob[u*ROBW +: ROBW]))); // R9

        for (genvar v = u + 1; v < UNITS; v++) begin : g_pair
            AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_valid[u] && issue_valid[v]) |->
                issue_rob[u*ROBW +: ROBW] != issue_rob[v*ROBW +: ROBW]); // R5
        end
    end

endmodule

bind iq_row_queue iq_row_queue_chk #(
    .UNITS(UNITS),
    .ROBW (ROBW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .issue_valid(issue_valid),
    .issue_rob  (issue_rob)
);

// File: tb/sim_iq_row_queue.sv
module sim_iq_row_queue;
    localparam int CLK_PERIOD = 10;
    localparam int COLS  = 2;
    localparam int ROWS  = 8;
    localparam int UNITS = 2;
    localparam int ROBW  = 6;
    localparam int SRCS  = 2;
    localparam int WAKES = 2;
    localparam int UW    = 1;

    logic clk = 1'b0;
    logic rst_n;
    logic flush;
    logic push_valid;
    logic push_ready;
    logic [COLS-1:0]            push_slot_valid;
    logic [COLS*UW-1:0]         push_unit;
    logic [COLS*ROBW-1:0]       push_rob;
    logic [COLS*SRCS*ROBW-1:0]  push_src_rob;
    logic [COLS*SRCS-1:0]       push_src_pend;
    logic [WAKES-1:0]           wake_valid;
    logic [WAKES*ROBW-1:0]      wake_rob;
    logic [UNITS-1:0]           issue_valid;
    logic [UNITS*ROBW-1:0]      issue_rob;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_row_queue #(
        .COLS(COLS), .ROWS(ROWS), .UNITS(UNITS), .ROBW(ROBW), .SRCS(SRCS), .WAKES(WAKES)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_valid(push_valid), .push_ready(push_ready),
        .push_slot_valid(push_slot_valid), .push_unit(push_unit), .push_rob(push_rob),
        .push_src_rob(push_src_rob), .push_src_pend(push_src_pend),
        .wake_valid(wake_valid), .wake_rob(wake_rob),
        .issue_valid(issue_valid), .issue_rob(issue_rob)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int port_rob(input int u);
        return int'(issue_rob[u*ROBW +: ROBW]);
    endfunction

    task automatic idle_inputs();
        flush = 1'b0; push_valid = 1'b0; push_slot_valid = '0; push_unit = '0;
        push_rob = '0; push_src_rob = '0; push_src_pend = '0;
        wake_valid = '0; wake_rob = '0;
    endtask

    task automatic set_slot(input int s, input bit v, input int unit, input int rob,
                            input int src, input bit pend);
        push_slot_valid[s] = v;
        push_unit[s*UW +: UW] = UW'(unit);
        push_rob[s*ROBW +: ROBW] = ROBW'(rob);
        push_src_rob[(s*SRCS)*ROBW +: ROBW] = ROBW'(src);
        push_src_pend[s*SRCS] = pend;
        push_src_pend[s*SRCS+1] = 1'b0;
    endtask

    task automatic wake(input int port, input int rob);
        wake_valid[port] = 1'b1;
        wake_rob[port*ROBW +: ROBW] = ROBW'(rob);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 issue_valid after reset", int'(issue_valid), 0);
        check("R1 push_ready after reset", int'(push_ready), 1);

        // ---- independent slots on both ports (R11, R5)
        set_slot(0, 1, 0, 1, 0, 0);
        set_slot(1, 1, 1, 2, 0, 0);
        push_valid = 1'b1;
        tick(); idle_inputs();
        check("R11 both ports valid", int'(issue_valid), 3);
        check("R5 port0 rob", port_rob(0), 1);
        check("R5 port1 rob", port_rob(1), 2);
        tick();
        check("R9 issued slots gone", int'(issue_valid), 0);

        // ---- wake key and in-queue chain (R6, R7)
        set_slot(0, 1, 0, 10, 41, 1);
        set_slot(1, 1, 0, 11, 10, 1);
        push_valid = 1'b1;
        tick(); idle_inputs();
        set_slot(0, 1, 1, 12, 11, 1);
        set_slot(1, 0, 0, 0, 0, 0);
        push_valid = 1'b1;
        tick(); idle_inputs();
        check("R6 waiting chain holds", int'(issue_valid), 0);
        wake(0, 43);
        tick(); idle_inputs();
        check("R6 foreign wake ignored", int'(issue_valid), 0);
        wake(1, 41);
        tick(); idle_inputs();
        check("R6 matching wake releases", int'(issue_valid), 1);
        check("R6 released rob", port_rob(0), 10);
        tick();
        check("R7 same-row consumer next", int'(issue_valid), 1);
        check("R7 consumer rob", port_rob(0), 11);
        tick();
        check("R7 cross-row consumer port", int'(issue_valid), 2);
        check("R7 cross-row consumer rob", port_rob(1), 12);
        tick();
        check("R9 chain drained", int'(issue_valid), 0);

        // ---- same-cycle resolution (R8)
        set_slot(0, 1, 0, 20, 42, 1);
        set_slot(1, 0, 0, 0, 0, 0);
        push_valid = 1'b1;
        wake(0, 42);
        tick(); idle_inputs();
        check("R8 wake in push cycle", int'(issue_valid), 1);
        check("R8 wake in push cycle rob", port_rob(0), 20);
        tick();
        set_slot(0, 1, 0, 21, 0, 0);
        push_valid = 1'b1;
        tick(); idle_inputs();
        check("R11 producer issues", port_rob(0), 21);
        set_slot(0, 1, 1, 22, 21, 1);
        push_valid = 1'b1;
        tick(); idle_inputs();
        check("R8 producer issuing in push cycle", int'(issue_valid), 2);
        check("R8 consumer rob", port_rob(1), 22);
        tick();

        // ---- fill, refuse, oldest first (R2, R3, R4)
        for (int r = 0; r < ROWS; r++) begin
            if (r == ROWS - 1) check("R3 ready before last row", int'(push_ready), 1);
            set_slot(0, 1, 0, 2*r, 40, 1);
            set_slot(1, (r != 3), 0, 2*r + 1, 40, 1);
            push_valid = 1'b1;
            tick(); idle_inputs();
        end
        check("R3 full queue not ready", int'(push_ready), 0);
        set_slot(0, 1, 1, 50, 0, 0);
        push_valid = 1'b1;
        tick(); idle_inputs();
        check("R3 refused push dropped", int'(issue_valid), 0);
        wake(0, 40);
        tick(); idle_inputs();
        for (int i = 0; i < 2*ROWS; i++) begin
            if (i == 7) continue;
            check("R4 oldest-first valid", int'(issue_valid), 1);
            check("R4 oldest-first rob", port_rob(0), i);
            if (i == 1) check("R3 ready while oldest row busy", int'(push_ready), 0);
            if (i == 2) check("R3 ready once oldest row empties", int'(push_ready), 1);
            tick();
        end
        check("R2 empty slot never issues", int'(issue_valid), 0);

        // ---- flush (R10)
        for (int r = 0; r < 2; r++) begin
            set_slot(0, 1, 0, 24 + 2*r, 44, 1);
            set_slot(1, 1, 1, 25 + 2*r, 44, 1);
            push_valid = 1'b1;
            tick(); idle_inputs();
        end
        flush = 1'b1;
        set_slot(0, 1, 0, 30, 0, 0);
        push_valid = 1'b1;
        tick(); idle_inputs();
        check("R10 nothing after flush", int'(issue_valid), 0);
        check("R10 ready after flush", int'(push_ready), 1);
        wake(0, 44);
        tick(); idle_inputs();
        check("R10 flushed slots stay gone", int'(issue_valid), 0);

        // ---- sweep of queue depths, both ports (R4, R5, R2)
        for (int n = 1; n <= ROWS; n++) begin
            for (int r = 0; r < n; r++) begin
                set_slot(0, 1, r % 2, 32 + 2*r, 60, 1);
                set_slot(1, 1, (r + 1) % 2, 33 + 2*r, 60, 1);
                push_valid = 1'b1;
                tick(); idle_inputs();
            end
            check("R6 sweep held", int'(issue_valid), 0);
            wake(1, 60);
            tick(); idle_inputs();
            for (int c = 0; c < n; c++) begin
                check("R5 sweep both ports", int'(issue_valid), 3);
                check("R4 sweep port0 order", port_rob(0), 32 + 2*c + (c % 2));
                check("R4 sweep port1 order", port_rob(1), 33 + 2*c - (c % 2));
                tick();
            end
            check("R9 sweep drained", int'(issue_valid), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule